// File: doc/BRIEF.md
# Frame-Aligned Triggered Capture Controller

This block sits on the output of a four-lane channelizer and forwards one complete frame of frequency bins to a set of per-lane buffers when software asks for it. Every clock may carry four complex samples (25-bit real plus 25-bit imaginary, 50 bits per lane) together with valid, start-of-frame and end-of-frame qualifiers. Beat k of a frame carries bins 4k to 4k+3, so a 512-bin frame takes 128 valid beats.

A one-clock trigger pulse arms the controller. It then waits for the next valid beat with the start-of-frame marker set and, from that beat on, writes 128 valid beats into the lane buffers, one write enable per lane. The last bin of the frame (lane 3 of the final beat) carries an end-of-packet flag. A busy output lets software see when the capture has completed. Because capture only ever begins on a frame boundary, the captured data is always one whole, bin-aligned frame with exactly one end marker.

Top module: `trig_frame_capture`

## Requirements
- R1: After reset all lane write enables, lane last flags and the busy output are low, and the controller is idle.
- R2: A trigger pulse while idle arms the controller; busy is high in the cycle after the trigger edge, and no lane is written in that cycle.
- R3: While armed, nothing is written until a beat with valid and start-of-frame both high; that beat is the first captured beat. A start-of-frame beat in the same cycle as the arming trigger is not captured. No lane is written while idle.
- R4: Each captured beat sets all four lane write enables high in the cycle after the beat's clock edge, with lane l's output data equal to input bits [50*l+49 : 50*l] of that beat.
- R5: During capture a beat with valid low writes nothing and does not count toward the 128 beats.
- R6: The last flag is high only on lane 3, only on the 128th captured beat, and exactly once per capture; lanes 0 to 2 always carry a zero last flag.
- R7: After the 128th beat the controller spends one cycle in its done state (busy still high, no writes for beats arriving then) and then returns to idle with busy low.
- R8: A trigger pulse while armed, capturing or done has no effect on the state, the count or the outputs.
- R9: Busy is high exactly from the cycle after arming through the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | One-cycle capture request |
| in_valid | input | 1 | Input beat is valid |
| in_sof | input | 1 | Input beat is the first of a frame |
| in_eof | input | 1 | Input beat is the last of a frame |
| in_data | input | 200 | Four lanes of 50-bit complex samples, lane l at bits [50*l+49:50*l] |
| lane_we | output | 4 | Per-lane buffer write enable |
| lane_data | output | 200 | Per-lane sample to write, same lane layout as the input |
| lane_last | output | 4 | Per-lane end-of-packet flag (only lane 3 is ever set) |
| busy | output | 1 | Capture armed, in progress or finishing |

## Verification
The assertions assume the channelizer presents well-formed frames: start-of-frame on the first valid beat of a frame and end-of-frame on its 128th valid beat, with invalid beats allowed anywhere in between, so the end-of-frame marker must coincide with the controller's final counted beat. The bench meets this by generating a frame stream from a beat index that advances only on valid beats, raising start-of-frame at index 0 and end-of-frame at index 127, while valid gaps, trigger timing and sample data are drawn at random. Directed cases place a trigger mid-frame, on a start-of-frame beat, and repeatedly while the controller is busy.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_e;

endpackage

// File: rtl/cap_fsm.sv
module cap_fsm
    import cap_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FRAME_BINS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic valid_i,
    input  logic sof_i,
    input  logic eof_i,
    output logic wr_o,
    output logic last_o,
    output logic busy_o
);

    localparam int BEATS = FRAME_BINS / LANES;
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef struct packed {
        cap_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;
    logic start_beat;
    logic final_beat;

    always_comb begin
        r_d        = r_q;
        start_beat = 1'b0;
        final_beat = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    r_d.st = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (valid_i && sof_i) begin
                    start_beat = 1'b1;
                    if (BEATS == 1) begin
                        final_beat = 1'b1;
                        r_d.st     = ST_DONE;
                    end else begin
                        r_d.st  = ST_CAPTURE;
                        r_d.cnt = CNT_W'(1);
                    end
                end
            end
            ST_CAPTURE: begin
                if (valid_i) begin
                    if (r_q.cnt == CNT_W'(BEATS - 1)) begin
                        final_beat = 1'b1;
                        r_d.st     = ST_DONE;
                        r_d.cnt    = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_o   = start_beat || (r_q.st == ST_CAPTURE && valid_i);
    assign last_o = final_beat;
    assign busy_o = (r_q.st != ST_IDLE);

    AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && trig_i) |=> (r_q.st == ST_ARMED)); // R2

    AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && !(valid_i && sof_i)) |=> (r_q.st == ST_ARMED)); // R3

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !wr_o); // R3

    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CAPTURE && !valid_i) |=> ($stable(r_q.cnt) && r_q.st == ST_CAPTURE)); // R5

    AST_EOF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        final_beat |-> eof_i); // R6

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE) |=> (r_q.st == ST_IDLE)); // R7

endmodule

// File: rtl/cap_lane_reg.sv
module cap_lane_reg #(
    parameter int SAMPLE_W = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                last_i,
    input  logic [SAMPLE_W-1:0] data_i,
    output logic                we_o,
    output logic                last_o,
    output logic [SAMPLE_W-1:0] data_o
);

    typedef struct packed {
        logic                we;
        logic                last;
        logic [SAMPLE_W-1:0] data;
    } lane_t;

    lane_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.we   = wr_i;
        r_d.last = wr_i && last_i;
        if (wr_i) begin
            r_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign we_o   = r_q.we;
    assign last_o = r_q.last;
    assign data_o = r_q.data;

    AST_LAST_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> we_o); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(data_o)); // R4

endmodule

// File: rtl/trig_frame_capture.sv
module trig_frame_capture #(
    parameter int LANES      = 4,
    parameter int SAMPLE_W   = 50,
    parameter int FRAME_BINS = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_i,
    input  logic                      in_valid,
    input  logic                      in_sof,
    input  logic                      in_eof,
    input  logic [LANES*SAMPLE_W-1:0] in_data,
    output logic [LANES-1:0]          lane_we,
    output logic [LANES*SAMPLE_W-1:0] lane_data,
    output logic [LANES-1:0]          lane_last,
    output logic                      busy
);

    localparam int LAST_LANE = LANES - 1;

    logic wr_beat;
    logic last_beat;

    cap_fsm #(
        .LANES      (LANES),
        .FRAME_BINS (FRAME_BINS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig_i),
        .valid_i (in_valid),
        .sof_i   (in_sof),
        .eof_i   (in_eof),
        .wr_o    (wr_beat),
        .last_o  (last_beat),
        .busy_o  (busy)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lane_last_in;
        if (l == LAST_LANE) begin : g_tail
            assign lane_last_in = last_beat;
        end else begin : g_body
            assign lane_last_in = 1'b0;
        end

        cap_lane_reg #(
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (wr_beat),
            .last_i (lane_last_in),
            .data_i (in_data[l*SAMPLE_W +: SAMPLE_W]),
            .we_o   (lane_we[l]),
            .last_o (lane_last[l]),
            .data_o (lane_data[l*SAMPLE_W +: SAMPLE_W])
        );
    end

    AST_LAST_TAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_last) && (lane_last == '0 || lane_last[LAST_LANE])); // R6

    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we == '0) || (&lane_we)); // R4

    AST_WRITE_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> busy); // R9

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_last) |=> (!busy && lane_we == '0)); // R7

endmodule

// File: tb/tb_trig_frame_capture.sv
module tb_trig_frame_capture;

    localparam int LANES    = 4;
    localparam int SW       = 50;
    localparam int BINS     = 512;
    localparam int BEATS    = BINS / LANES;
    localparam int DW       = LANES * SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trig_i;
    logic          in_valid;
    logic          in_sof;
    logic          in_eof;
    logic [DW-1:0] in_data;
    logic [LANES-1:0] lane_we;
    logic [DW-1:0]    lane_data;
    logic [LANES-1:0] lane_last;
    logic             busy;

    always #4 clk = ~clk;

    trig_frame_capture #(
        .LANES (LANES), .SAMPLE_W (SW), .FRAME_BINS (BINS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .trig_i (trig_i),
        .in_valid (in_valid), .in_sof (in_sof), .in_eof (in_eof),
        .in_data (in_data), .lane_we (lane_we), .lane_data (lane_data),
        .lane_last (lane_last), .busy (busy)
    );

    int checks = 0;
    int bad    = 0;
    bit finished = 1'b0;

    // bench reference state: 0 idle, 1 armed, 2 capture, 3 done
    int m_st  = 0;
    int m_cnt = 0;
    int gidx  = 0;          // frame generator beat index
    int captures = 0;
    int lasts_seen = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rand_data();
        logic [DW-1:0] d;
        for (int l = 0; l < LANES; l++) begin
            d[l*SW +: SW] = SW'({$urandom, $urandom});
        end
        return d;
    endfunction

    // one beat: called at a negedge, drives inputs, checks after next posedge
    task automatic beat(input bit trig, input bit v);
        bit exp_we, exp_last, prev_done, armed_now, trig_busy;
        logic [DW-1:0] d;
        d        = rand_data();
        trig_i   = trig;
        in_valid = v;
        in_sof   = v && (gidx == 0);
        in_eof   = v && (gidx == BEATS - 1);
        in_data  = d;
        exp_we = 0; exp_last = 0; prev_done = 0; armed_now = 0; trig_busy = 0;
        case (m_st)
            0: if (trig) begin m_st = 1; armed_now = 1; end
            1: begin
                trig_busy = trig;
                if (v && gidx == 0) begin
                    exp_we = 1; m_cnt = 1; m_st = 2;
                end
            end
            2: begin
                trig_busy = trig;
                if (v) begin
                    exp_we = 1;
                    if (m_cnt == BEATS - 1) begin exp_last = 1; m_st = 3; captures++; end
                    else m_cnt++;
                end
            end
            default: begin trig_busy = trig; prev_done = 1; m_st = 0; end
        endcase
        if (v) gidx = (gidx + 1) % BEATS;
        @(posedge clk);
        @(negedge clk);
        begin
            string tw;
            string tb;
            tw = exp_last ? "R6" : (exp_we ? "R4" : (prev_done ? "R7" : (m_st == 2 ? "R5" : "R3")));
            tb = armed_now ? "R2" : (trig_busy ? "R8" : (prev_done ? "R7" : "R9"));
            chk(lane_we == (exp_we ? {LANES{1'b1}} : '0), tw, DW'(lane_we),
                DW'(exp_we ? {LANES{1'b1}} : {LANES{1'b0}}));
            chk(lane_last == (exp_last ? 4'b1000 : 4'b0000), "R6", DW'(lane_last),
                DW'(exp_last ? 4'b1000 : 4'b0000));
            chk(busy == (m_st != 0), tb, DW'(busy), DW'(m_st != 0));
            if (exp_we) chk(lane_data == d, "R4", lane_data, d);
            if (lane_last[3]) lasts_seen++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; trig_i = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(lane_we == '0, "R1", DW'(lane_we), '0);
        chk(lane_last == '0, "R1", DW'(lane_last), '0);
        chk(busy == 1'b0, "R1", DW'(busy), '0);

        // R3: trigger mid-frame, capture waits for next start-of-frame
        for (int i = 0; i < 5; i++) beat(0, 1);
        beat(1, 1);
        for (int i = 0; i < 300; i++) beat(0, 1);

        // R3: trigger on the start-of-frame beat itself is not captured
        while (gidx != 0) beat(0, 1);
        beat(1, 1);
        for (int i = 0; i < 300; i++) beat(0, 1);

        // R8: triggers repeatedly while busy
        beat(1, 1);
        for (int i = 0; i < 400; i++) beat((i % 7) == 3, 1);

        // R5: sparse valid, random triggers
        for (int i = 0; i < 6000; i++) beat(($urandom % 50) == 0, ($urandom % 100) < 60);
        // dense random
        for (int i = 0; i < 3000; i++) beat(($urandom % 30) == 0, ($urandom % 100) < 95);
        for (int i = 0; i < 300; i++) beat(0, 1);

        // R6: one last flag per capture
        chk(lasts_seen == captures, "R6", DW'(lasts_seen), DW'(captures));
        chk(captures >= 3, "R6", DW'(captures), DW'(3));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule